// File: doc/BRIEF.md
# Bit Gather Unit

The unit builds an 8-bit value out of eight bits picked from a 64-bit data word. A second 64-bit operand, the selector word, carries eight 8-bit indices, one per byte. Each index names a bit of the data word, numbered from the most significant end. An index of 64 or more names no bit, and that output bit reads as zero. The eight gathered bits sit in the low byte of a 64-bit result. Every bit above the low byte is zero.

The gather logic is purely combinational. With `REGISTERED` set to 1 (the default), a one-entry output register sits behind it, using a valid/ready handshake on both sides. An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` after that edge. While `out_valid` is high and `out_ready` is low, the held result and `out_valid` do not change, and `in_ready` stays low, so back-pressure reaches the producer in the same cycle. With `REGISTERED` set to 0, the result follows the inputs directly, `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`.

Top module: `bit_gather_unit`

## Requirements
- R1: Index k (k = 0..7) is read from selector bits [63-8k : 56-8k] in LSB-0 numbering, so index 0 is the most significant byte.
- R2: For an index below 64, gathered bit k equals the data bit at MSB-first position `index`, which is LSB-0 bit 63-index.
- R3: For an index of 64 or more, gathered bit k is 0. Values 64, 127, 128 and 255 never alias to a lower bit position.
- R4: Gathered bit k drives result bit 7-k (LSB-0), so gathered bit 0 is the most significant bit of the low byte.
- R5: Result bits [63:8] are always zero.
- R6: A pair accepted on a clock edge (`in_valid` and `in_ready` both high) produces `out_valid` high and its result after that same edge.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_result` hold their values. Otherwise `in_ready` is high.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_result` to zero on the next edge.
- R9: Several indices with the same value each return the same data bit, independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is valid |
| in_ready | output | 1 | Unit can accept a pair this cycle |
| in_sel | input | 64 | Selector word holding eight byte indices |
| in_data | input | 64 | Data word the bits are gathered from |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Gathered byte, zero-extended |

## Verification
Ascending indices 0..7 return the top data byte unchanged, and descending indices 7..0 move a single set bit to the other end of the byte. Together these separate correct byte extraction from the wrong byte order and from the wrong end of the result. Indices of 64, 127, 128, 200 and 255 against an all-ones data word expose any truncated range compare. Alternating 63 and 64 against a data word with only its lowest bit set exercises the exact boundary. Eight copies of one index test duplicate selection. Random operands and random consumer stalls are compared against a behavioural reference every cycle, which also exercises the hold rules under back-pressure.

// File: rtl/bgu_pkg.sv
package bgu_pkg;
  localparam int BGU_DATA_W = 64;
  localparam int BGU_IDX_W  = 8;
  localparam int BGU_N_SEL  = BGU_DATA_W / BGU_IDX_W;
endpackage

// File: rtl/bgu_lane.sv
module bgu_lane #(
  parameter int DATA_W = bgu_pkg::BGU_DATA_W,
  parameter int IDX_W  = bgu_pkg::BGU_IDX_W
) (
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [DATA_W-1:0] data,
  output logic              bit_o
);
  localparam int POS_W = $clog2(DATA_W);
  localparam logic [IDX_W:0]   LIMIT   = (IDX_W+1)'(DATA_W);
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(DATA_W - 1);

  logic             in_range;
  logic [POS_W-1:0] pos;

  // Full-width compare: no upper index bit is dropped.
  assign in_range = ({1'b0, sel_idx} < LIMIT);
  // MSB-first position p maps to LSB-0 bit DATA_W-1-p.
  assign pos      = TOP_POS - sel_idx[POS_W-1:0];
  assign bit_o    = in_range & data[pos];
endmodule

// File: rtl/bgu_gather.sv
module bgu_gather #(
  parameter int DATA_W = bgu_pkg::BGU_DATA_W,
  parameter int IDX_W  = bgu_pkg::BGU_IDX_W,
  parameter int N_SEL  = DATA_W / IDX_W
) (
  input  logic [DATA_W-1:0] sel_word,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] result
);
  localparam int PAD_W = DATA_W - N_SEL;

  logic [N_SEL-1:0] gathered;

  for (genvar k = 0; k < N_SEL; k++) begin : g_lane
    logic [IDX_W-1:0] idx_k;
    // Index k occupies the k-th byte counted from the MSB end.
    assign idx_k = sel_word[DATA_W-1-IDX_W*k -: IDX_W];
    bgu_lane #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_lane (
      .sel_idx (idx_k),
      .data    (data),
      .bit_o   (gathered[N_SEL-1-k])
    );
  end

  assign result = {{PAD_W{1'b0}}, gathered};
endmodule

// File: rtl/bgu_out_stage.sv
module bgu_out_stage #(
  parameter int DATA_W     = bgu_pkg::BGU_DATA_W,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_res,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_res
);
  if (REGISTERED) begin : g_reg
    logic              vld_q;
    logic [DATA_W-1:0] res_q;
    logic              can_load;

    assign can_load = !vld_q || out_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else if (can_load) begin
        vld_q <= in_valid;
        if (in_valid) res_q <= in_res;
      end
    end

    assign in_ready  = can_load;
    assign out_valid = vld_q;
    assign out_res   = res_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_res   = in_res;
  end
endmodule

// File: rtl/bit_gather_unit.sv
module bit_gather_unit #(
  parameter int DATA_W     = bgu_pkg::BGU_DATA_W,
  parameter int IDX_W      = bgu_pkg::BGU_IDX_W,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_sel,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result
);
  localparam int N_SEL = DATA_W / IDX_W;

  logic [DATA_W-1:0] comb_res;

  bgu_gather #(.DATA_W(DATA_W), .IDX_W(IDX_W), .N_SEL(N_SEL)) u_gather (
    .sel_word (in_sel),
    .data     (in_data),
    .result   (comb_res)
  );

  bgu_out_stage #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_res    (comb_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (out_result)
  );
endmodule

// File: rtl/bgu_checker.sv
module bgu_checker #(
  parameter int DATA_W     = 64,
  parameter int IDX_W      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_sel,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result
);
  localparam int N_SEL = DATA_W / IDX_W;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DATA_W);

  logic first_oor;
  assign first_oor = ({1'b0, in_sel[DATA_W-1 -: IDX_W]} >= LIMIT);

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    out_result[DATA_W-1:N_SEL] == '0);

  if (REGISTERED) begin : g_seq
    p_accept_r6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

    p_clear_r8: assert property (@(posedge clk)
      rst |=> (!out_valid && out_result == '0));

    p_oor_zero_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && first_oor) |=> !out_result[N_SEL-1]);
  end
endmodule

bind bit_gather_unit bgu_checker #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .REGISTERED(REGISTERED)
) u_bgu_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sel     (in_sel),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/bit_gather_unit_bench.sv
module bit_gather_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_sel = '0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit_gather_unit u_bit_gather_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sel(in_sel), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] ref_gather(logic [63:0] s, logic [63:0] d);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      int idx = int'(s[63-8*k -: 8]);
      if (idx < 64) r[7-k] = d[63-idx];
    end
    return r;
  endfunction

  // Behavioural reference of the one-entry output register.
  bit          m_vld = 1'b0;
  logic [63:0] m_res = '0;
  always @(posedge clk) begin
    if (rst) begin
      m_vld <= 1'b0;
      m_res <= '0;
    end else if (!m_vld || out_ready) begin
      m_vld <= in_valid;
      if (in_valid) m_res <= ref_gather(in_sel, in_data);
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-cycle comparison, sampled at the falling edge.
  always @(negedge clk) begin
    if (!done) begin
      check("R6 out_valid", {63'b0, out_valid}, {63'b0, m_vld});
      check("R7 in_ready", {63'b0, in_ready}, {63'b0, (!m_vld || out_ready)});
      check("R2 result", out_result, m_res);
      check("R5 upper", {8'b0, out_result[63:8]}, '0);
    end
  end

  task automatic one_op(string req, logic [63:0] s, logic [63:0] d, logic [63:0] exp);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_sel = s; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_result, exp);
    check({req, " valid"}, {63'b0, out_valid}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset valid", {63'b0, out_valid}, '0);
    check("R8 reset result", out_result, '0);
    rst = 1'b0;

    // R1 R2 R4: ascending indices return the top data byte
    one_op("R1", 64'h0001_0203_0405_0607, 64'hA5C3_0000_0000_0000, 64'hA5);
    // R4: descending indices move position 0 to result bit 0
    one_op("R4", 64'h0706_0504_0302_0100, 64'h8000_0000_0000_0000, 64'h01);
    // R3: out-of-range values never alias
    one_op("R3", 64'h407F_80FF_40C8_64FF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h00);
    // R3 R2: boundary 63 vs 64
    one_op("R3 boundary", 64'h3F40_3F40_3F40_3F40, 64'h1, 64'hAA);
    // R9: duplicates of index 5
    one_op("R9", 64'h0505_0505_0505_0505, 64'h0400_0000_0000_0000, 64'hFF);

    // R7: stall holds result and blocks input
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    in_sel = 64'h0001_0203_0405_0607; in_data = 64'h3C00_0000_0000_0000;
    @(negedge clk);
    in_sel = 64'h0;  in_data = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) begin
      @(negedge clk);
      check("R7 hold", out_result, 64'h3C);
      check("R7 ready low", {63'b0, in_ready}, '0);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);

    // R8: reset mid-stream clears a held result
    in_valid = 1'b1; in_sel = '0; in_data = 64'h8000_0000_0000_0000;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R8 clear", {out_result[63:1], out_valid}, '0);
    rst = 1'b0;

    // Random operands with random stalls (R2 R6 R7 via per-cycle model)
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      in_valid  = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 2) != 0);
      in_sel  = {$urandom, $urandom};
      if (n % 2 == 0) in_sel = in_sel & 64'h3F3F_3F3F_3F3F_3F3F;
      in_data = {$urandom, $urandom};
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    done = 1'b1;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule